// File: doc/BRIEF.md
# Wide Error-Bin Counter Extender with Atomic Snapshot

This block widens a set of narrow, free-running error-bin counters, which wrap around, into wide counters that software can read. It runs on the configuration-bus clock. It samples every narrow source counter on each clock. It takes the difference from the previous sample, modulo the source width, and adds that difference to a wide accumulator for the same bin. The result is correct as long as no source advances by a full source range or more between two clocks. The accumulators saturate and never wrap.

Software reads the counters through shadow copies, never live. The snapshot request is the OR of a dedicated input pin and bit 0 of a control register. When this combined request goes from low to high, every accumulator is copied into its shadow register on the same clock edge. The shadows then stay frozen while accumulation continues. A new capture needs the request to fall and rise again.

The register side is a plain address/write-strobe port with combinational read data. The control word sits at 0x1E0. The shadows sit in the window starting at 0x904, one 32-bit word per bin.

Top module: `binCounterWidener`

## Requirements
- R1: After a synchronous reset, every shadow register reads 0, the control word at 0x1E0 reads 0, and the accumulators and stored previous samples are 0.
- R2: On every clock out of reset, each bin's accumulator grows by (current source value − previous source value) mod 2^SRC_W, so a source wrapping from 250 to 4 adds 10.
- R3: An accumulator that would exceed 2^ACC_W − 1 stays at 2^ACC_W − 1 and does not wrap.
- R4: Writing 1 to bit 0 of the control word at address 0x1E0 raises the request; on the next edge all shadows take the accumulator values from that same instant.
- R5: A rising edge on the snapReq input, with the control bit clear, captures all shadows on the edge where it is first seen high.
- R6: A capture happens only on a low-to-high change of (snapReq OR control bit); while the request stays high the shadows hold, even when the sources keep counting or the other request source rises.
- R7: A read of 0x1E0 returns the control bit in bit 0 and zeros in all other bits.
- R8: A read of any address that is neither 0x1E0 nor a shadow slot returns 0.
- R9: The shadow of bin i is read at 0x904 + 4·i, zero-extended to 32 bits.
- R10: Each bin counts only its own source; a change on one source leaves the other bins' counts unchanged.
- R11: Writes to any address other than 0x1E0 change neither the control bit nor any shadow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous reset, active high |
| snapReq | input | 1 | Snapshot request pin, ORed with the control bit |
| binCount | input | NUM_BINS*SRC_W | Narrow source counters, bin 0 in the low bits |
| regAddr | input | ADDR_W | Register byte address |
| regWrEn | input | 1 | Write strobe for one cycle |
| regWrBit | input | 1 | Value written to the control bit (the only writable field) |
| regRdData | output | DATA_W | Combinational read data for regAddr |

## Verification
The bench builds the block with four 8-bit bins, the 32-bit register port, and a 16-bit accumulator in place of the default 32 bits. The narrower accumulator lets saturation be reached in a few hundred cycles of large increments. It also exercises the zero-extension of a shadow into the wider read word. The 8-bit sources allow wrap-around deltas to be placed exactly. The address map keeps its default values, so the control word and shadow slots are checked at their real offsets.

// File: rtl/binWidenPkg.sv
package binWidenPkg;

  // Strobes from the control side to the datapath.
  typedef struct packed {
    logic       capture;    // copy every accumulator into its shadow this edge
    logic       selCtrl;    // read address hits the control word
    logic       selShadow;  // read address hits a shadow slot
    logic [7:0] shadowIdx;  // which shadow slot is addressed
  } widenStrobes_t;

endpackage

// File: rtl/widenCtrl.sv
module widenCtrl
  import binWidenPkg::*;
#(
  parameter int          NUM_BINS      = 4,
  parameter int          ADDR_W        = 12,
  parameter logic [11:0] CTRL_ADDR     = 12'h1E0,
  parameter logic [11:0] SHADOW_BASE   = 12'h904,
  parameter int          SHADOW_STRIDE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snapReq,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regWrBit,
  output widenStrobes_t     strobes,
  output logic              reqBit
);

  logic ctrlHit;
  logic reqComb;
  logic reqDly;
  logic [NUM_BINS-1:0] slotHit;

  assign ctrlHit = (regAddr == ADDR_W'(CTRL_ADDR));

  genvar gi;
  generate
    for (gi = 0; gi < NUM_BINS; gi++) begin : g_slot
      localparam logic [ADDR_W-1:0] SLOT_ADDR =
        ADDR_W'(SHADOW_BASE) + ADDR_W'(gi * SHADOW_STRIDE);
      assign slotHit[gi] = (regAddr == SLOT_ADDR);
    end
  endgenerate

  // Control bit: only a write to the control address can change it.
  always_ff @(posedge clk) begin
    if (rst) begin
      reqBit <= 1'b0;
    end else if (regWrEn && ctrlHit) begin
      reqBit <= regWrBit;
    end
  end

  // The two request sources are merged first; a capture needs the merged level to rise.
  assign reqComb = snapReq | reqBit;

  always_ff @(posedge clk) begin
    if (rst) begin
      reqDly <= 1'b0;
    end else begin
      reqDly <= reqComb;
    end
  end

  always_comb begin
    strobes           = '0;
    strobes.capture   = reqComb & ~reqDly;
    strobes.selCtrl   = ctrlHit;
    strobes.selShadow = |slotHit;
    for (int i = 0; i < NUM_BINS; i++) begin
      if (slotHit[i]) begin
        strobes.shadowIdx = 8'(i);
      end
    end
  end

endmodule

// File: rtl/binAccumulator.sv
module binAccumulator #(
  parameter int SRC_W = 8,
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_W-1:0] srcVal,
  input  logic             capture,
  output logic [ACC_W-1:0] accVal,
  output logic [ACC_W-1:0] shadowVal
);

  localparam int SUM_W = ACC_W + 1;

  logic [SRC_W-1:0] prevVal;
  logic [SRC_W-1:0] delta;
  logic [SUM_W-1:0] sum;

  // Modulo subtraction: the wrap of the narrow source is absorbed by the width.
  assign delta = srcVal - prevVal;
  assign sum   = {1'b0, accVal} + SUM_W'(delta);

  always_ff @(posedge clk) begin
    if (rst) begin
      prevVal <= '0;
      accVal  <= '0;
    end else begin
      prevVal <= srcVal;
      accVal  <= sum[ACC_W] ? {ACC_W{1'b1}} : sum[ACC_W-1:0];
    end
  end

  // The shadow takes the accumulator value as it stands before this edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      shadowVal <= '0;
    end else if (capture) begin
      shadowVal <= accVal;
    end
  end

endmodule

// File: rtl/widenDatapath.sv
module widenDatapath
  import binWidenPkg::*;
#(
  parameter int NUM_BINS = 4,
  parameter int SRC_W    = 8,
  parameter int ACC_W    = 32,
  parameter int DATA_W   = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_BINS*SRC_W-1:0] binCount,
  input  widenStrobes_t             strobes,
  input  logic                      reqBit,
  output logic [NUM_BINS*ACC_W-1:0] accFlat,
  output logic [NUM_BINS*ACC_W-1:0] shadowFlat,
  output logic [DATA_W-1:0]         rdData
);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_BINS; gi++) begin : g_bin
      binAccumulator #(
        .SRC_W(SRC_W),
        .ACC_W(ACC_W)
      ) u_acc (
        .clk      (clk),
        .rst      (rst),
        .srcVal   (binCount[gi*SRC_W +: SRC_W]),
        .capture  (strobes.capture),
        .accVal   (accFlat[gi*ACC_W +: ACC_W]),
        .shadowVal(shadowFlat[gi*ACC_W +: ACC_W])
      );
    end
  endgenerate

  always_comb begin
    rdData = '0;
    if (strobes.selCtrl) begin
      rdData[0] = reqBit;
    end else if (strobes.selShadow) begin
      for (int i = 0; i < NUM_BINS; i++) begin
        if (strobes.shadowIdx == 8'(i)) begin
          rdData[ACC_W-1:0] = shadowFlat[i*ACC_W +: ACC_W];
        end
      end
    end
  end

endmodule

// File: rtl/binCounterWidener.sv
module binCounterWidener
  import binWidenPkg::*;
#(
  parameter int          NUM_BINS      = 4,
  parameter int          SRC_W         = 8,
  parameter int          ACC_W         = 32,
  parameter int          DATA_W        = 32,
  parameter int          ADDR_W        = 12,
  parameter logic [11:0] CTRL_ADDR     = 12'h1E0,
  parameter logic [11:0] SHADOW_BASE   = 12'h904,
  parameter int          SHADOW_STRIDE = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      snapReq,
  input  logic [NUM_BINS*SRC_W-1:0] binCount,
  input  logic [ADDR_W-1:0]         regAddr,
  input  logic                      regWrEn,
  input  logic                      regWrBit,
  output logic [DATA_W-1:0]         regRdData
);

  widenStrobes_t             strobes;
  logic                      reqBit;
  logic [NUM_BINS*ACC_W-1:0] accFlat;
  logic [NUM_BINS*ACC_W-1:0] shadowFlat;

  widenCtrl #(
    .NUM_BINS     (NUM_BINS),
    .ADDR_W       (ADDR_W),
    .CTRL_ADDR    (CTRL_ADDR),
    .SHADOW_BASE  (SHADOW_BASE),
    .SHADOW_STRIDE(SHADOW_STRIDE)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .snapReq (snapReq),
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .regWrBit(regWrBit),
    .strobes (strobes),
    .reqBit  (reqBit)
  );

  widenDatapath #(
    .NUM_BINS(NUM_BINS),
    .SRC_W   (SRC_W),
    .ACC_W   (ACC_W),
    .DATA_W  (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .binCount  (binCount),
    .strobes   (strobes),
    .reqBit    (reqBit),
    .accFlat   (accFlat),
    .shadowFlat(shadowFlat),
    .rdData    (regRdData)
  );

endmodule

// File: rtl/binWidenerChecker.sv
module binWidenerChecker #(
  parameter int          NUM_BINS      = 4,
  parameter int          ACC_W         = 32,
  parameter int          DATA_W        = 32,
  parameter int          ADDR_W        = 12,
  parameter logic [11:0] CTRL_ADDR     = 12'h1E0,
  parameter logic [11:0] SHADOW_BASE   = 12'h904,
  parameter int          SHADOW_STRIDE = 4
) (
  input logic                      clk,
  input logic                      rst,
  input logic [ADDR_W-1:0]         regAddr,
  input logic [DATA_W-1:0]         regRdData,
  input logic                      capture,
  input logic [NUM_BINS*ACC_W-1:0] accFlat,
  input logic [NUM_BINS*ACC_W-1:0] shadowFlat
);

  logic mapped;
  always_comb begin
    mapped = (regAddr == ADDR_W'(CTRL_ADDR));
    for (int i = 0; i < NUM_BINS; i++) begin
      if (regAddr == ADDR_W'(SHADOW_BASE) + ADDR_W'(i * SHADOW_STRIDE)) begin
        mapped = 1'b1;
      end
    end
  end

  // R6: shadows only move on a capture edge
  p_shadow_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(shadowFlat));

  // R6: a capture needs the request to fall before it can fire again
  p_single_capture_r6: assert property (@(posedge clk) disable iff (rst)
    capture |=> !capture);

  // R8: unmapped reads return zero
  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !mapped |-> regRdData == '0);

  // R7: the control word carries only bit 0
  p_ctrl_upper_zero_r7: assert property (@(posedge clk) disable iff (rst)
    regAddr == ADDR_W'(CTRL_ADDR) |-> regRdData[DATA_W-1:1] == '0);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_BINS; gi++) begin : g_chk
      // R2: accumulators never move backwards
      p_monotone_r2: assert property (@(posedge clk) disable iff (rst)
        accFlat[gi*ACC_W +: ACC_W] >= $past(accFlat[gi*ACC_W +: ACC_W]));
      // R3: a saturated accumulator stays saturated
      p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (&accFlat[gi*ACC_W +: ACC_W]) |=> (&accFlat[gi*ACC_W +: ACC_W]));
    end
  endgenerate

endmodule

bind binCounterWidener binWidenerChecker #(
  .NUM_BINS     (NUM_BINS),
  .ACC_W        (ACC_W),
  .DATA_W       (DATA_W),
  .ADDR_W       (ADDR_W),
  .CTRL_ADDR    (CTRL_ADDR),
  .SHADOW_BASE  (SHADOW_BASE),
  .SHADOW_STRIDE(SHADOW_STRIDE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .regAddr   (regAddr),
  .regRdData (regRdData),
  .capture   (strobes.capture),
  .accFlat   (accFlat),
  .shadowFlat(shadowFlat)
);

// File: tb/sim_binCounterWidener.sv
module sim_binCounterWidener;

  localparam int CLK_PERIOD = 10;
  localparam int NB      = 4;
  localparam int SW      = 8;
  localparam int AW      = 16;
  localparam int DW      = 32;
  localparam int ADW     = 12;
  localparam longint SAT = (64'd1 << AW) - 1;
  localparam logic [11:0] CTRL  = 12'h1E0;
  localparam logic [11:0] SBASE = 12'h904;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           snapReq = 1'b0;
  logic [NB*SW-1:0] binCount = '0;
  logic [ADW-1:0] regAddr = '0;
  logic           regWrEn = 1'b0;
  logic           regWrBit = 1'b0;
  logic [DW-1:0]  regRdData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int     srcVal [NB];
  longint expAcc [NB];
  longint snapExp[NB];

  always #(CLK_PERIOD/2) clk = ~clk;

  binCounterWidener #(
    .NUM_BINS(NB), .SRC_W(SW), .ACC_W(AW), .DATA_W(DW), .ADDR_W(ADW)
  ) u0 (
    .clk(clk), .rst(rst), .snapReq(snapReq), .binCount(binCount),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrBit(regWrBit),
    .regRdData(regRdData)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic readReg(input logic [ADW-1:0] addr, output logic [DW-1:0] val);
    regAddr = addr;
    #1;
    val = regRdData;
  endtask

  // Drive new source values; the model adds the modulo deltas with saturation.
  task automatic applySrc(input int v0, input int v1, input int v2, input int v3);
    int nv[NB];
    nv[0] = v0; nv[1] = v1; nv[2] = v2; nv[3] = v3;
    for (int i = 0; i < NB; i++) begin
      longint d;
      d = (nv[i] - srcVal[i]) & 255;
      expAcc[i] = (expAcc[i] + d > SAT) ? SAT : expAcc[i] + d;
      srcVal[i] = nv[i] & 255;
      binCount[i*SW +: SW] = SW'(srcVal[i]);
    end
    tick();
  endtask

  task automatic writeReg(input logic [ADW-1:0] addr, input logic bitVal);
    regAddr  = addr;
    regWrEn  = 1'b1;
    regWrBit = bitVal;
    tick();
    regWrEn  = 1'b0;
    regWrBit = 1'b0;
    tick();
  endtask

  task automatic saveSnap();
    for (int i = 0; i < NB; i++) snapExp[i] = expAcc[i];
  endtask

  task automatic checkShadows(input string tag);
    logic [DW-1:0] v;
    for (int i = 0; i < NB; i++) begin
      readReg(SBASE + 12'(4 * i), v);
      check(tag, v, DW'(snapExp[i]));
    end
  endtask

  task automatic testReset();
    logic [DW-1:0] v;
    snapExp = '{default: 0};
    checkShadows("R1 shadow after reset");
    readReg(CTRL, v);
    check("R1 R7 control after reset", v, 32'h0);
  endtask

  task automatic testAccumulate();
    logic [DW-1:0] v;
    applySrc(10, 20, 30, 40);
    applySrc(15, 20, 100, 41);
    saveSnap();
    writeReg(CTRL, 1'b1);
    checkShadows("R2 R4 R9 R10 per-bin totals");
    readReg(CTRL, v);
    check("R7 control reads set", v, 32'h1);
    writeReg(CTRL, 1'b0);
    readReg(CTRL, v);
    check("R7 control reads clear", v, 32'h0);
  endtask

  task automatic testWrap();
    applySrc(250, 200, 100, 41);
    applySrc(4, 255, 100, 41);
    applySrc(4, 0, 100, 41);
    applySrc(4, 5, 100, 41);
    saveSnap();
    writeReg(CTRL, 1'b1);
    checkShadows("R2 wrap delta");
    writeReg(CTRL, 1'b0);
  endtask

  task automatic testHoldAndPort();
    saveSnap();
    writeReg(CTRL, 1'b1);
    applySrc(30, 60, 150, 50);
    applySrc(40, 70, 160, 55);
    tick();
    checkShadows("R6 shadow holds while counting");
    snapReq = 1'b1;
    tick(); tick();
    checkShadows("R6 port rise ignored while bit set");
    writeReg(CTRL, 1'b0);
    checkShadows("R6 clearing one source no capture");
    snapReq = 1'b0;
    tick();
    applySrc(45, 71, 170, 56);
    saveSnap();
    snapReq = 1'b1;
    tick();
    checkShadows("R5 port rising edge captures");
    tick();
    snapReq = 1'b0;
    tick();
  endtask

  task automatic testSaturate();
    int v3;
    v3 = srcVal[3];
    for (int k = 0; k < 400; k++) begin
      v3 = (v3 + 200) & 255;
      applySrc(srcVal[0], srcVal[1], srcVal[2], v3);
    end
    saveSnap();
    check("R3 model reached ceiling", DW'(snapExp[3]), DW'(SAT));
    writeReg(CTRL, 1'b1);
    checkShadows("R3 saturation and R10 other bins");
    writeReg(CTRL, 1'b0);
  endtask

  task automatic testUnmapped();
    logic [DW-1:0] v;
    readReg(12'h000, v); check("R8 unmapped 0x000", v, 32'h0);
    readReg(12'h900, v); check("R8 unmapped 0x900", v, 32'h0);
    readReg(12'h914, v); check("R8 unmapped 0x914", v, 32'h0);
    readReg(12'h1E4, v); check("R8 unmapped 0x1E4", v, 32'h0);
    readReg(12'h906, v); check("R8 unmapped 0x906", v, 32'h0);
  endtask

  task automatic testWriteIgnored();
    logic [DW-1:0] v;
    writeReg(12'h904, 1'b1);
    writeReg(12'h1E4, 1'b1);
    writeReg(12'h000, 1'b1);
    readReg(CTRL, v);
    check("R11 stray writes leave control clear", v, 32'h0);
    checkShadows("R11 stray writes leave shadows");
  endtask

  initial begin
    for (int i = 0; i < NB; i++) begin
      srcVal[i] = 0;
      expAcc[i] = 0;
    end
    repeat (4) tick();
    rst = 1'b0;
    tick();
    testReset();
    testAccumulate();
    testWrap();
    testHoldAndPort();
    testSaturate();
    testUnmapped();
    testWriteIgnored();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule